// File: doc/BRIEF.md
# Grouped Active Priority Tracker

This block records which interrupt priority levels are currently active for a virtual CPU interface. It holds one bank of bits for each of the two interrupt groups, and each bank has up to four 32-bit words. A 3-bit configuration field gives the number of implemented preemption bits. That count sets how many words are live and the minimum binary point used to turn priorities into bit positions.

The block has three operations. A set marks a priority as active in its group's bank. The priority is first reduced to a preemption level by the binary point that applies to that group. The running priority is always on an output, and it is the highest active level across both banks together. A drop removes the highest active level, choosing between the two groups, and reports the level it removed one cycle later. Whole words can be read and written by group and index, so that a hypervisor can save and restore the state.

Top module: `apt_tracker`

## Requirements
- R1: After reset every word of both banks is zero, `run_pri_o` is 0xFF, and `drop_vld_o` and `set_err_o` are 0.
- R2: The preemption-bit count is `cfg_prebits_fld`+1, clamped into the range 5..7. The live word count is 1 << (count-5), which gives 1, 2 or 4 words. The minimum binary point is 8 minus the count.
- R3: A group-0 set (`set_grp_i`=0) masks the priority with 0xFF << (`bp0_i`+1). When `bp0_i`=7 the mask is zero.
- R4: A group-1 set masks with 0xFF << `bp1_i` when `bp_common_i`=0. When `bp_common_i`=1 it masks with 0xFF << min(`bp0_i`+1, 7).
- R5: A set turns the masked level into index = level >> minimum binary point. It sets bit index%32 of word index/32 in the group's bank, and the change is visible the cycle after the request.
- R6: `run_pri_o` ORs the two banks word by word over the live words. In the lowest nonzero word w with lowest set bit b it shows (32*w+b) << minimum binary point, truncated to 8 bits. It shows 0xFF when all live words are zero.
- R7: A drop acts on the lowest word where either bank has a bit set. It clears group 0's lowest bit only if that bit's position is strictly below group 1's lowest bit, and otherwise clears group 1's lowest bit. An empty bank counts as position 32. One cycle later `drop_vld_o`=1, `drop_pri_o` holds the rescaled level of the cleared bit, and `drop_grp_o` holds the group that was cleared.
- R8: A drop with nothing active changes no word. One cycle later it reports `drop_pri_o`=0xFF and `drop_grp_o`=0.
- R9: `wacc_rdata_o` shows the selected word of bank `wacc_grp_i` at index `wacc_idx_i` combinationally. A write with `wacc_we_i` stores `wacc_wdata_i` at the next edge. A write to an index at or above the live word count is ignored, and a read of such an index returns zero.
- R10: When a set and a drop are requested in the same cycle, the drop is performed and the set is discarded. `set_err_o` is 1 in the following cycle.
- R11: A word write in the same cycle as a set or a drop is applied first, and the set bit or drop clear lands on top of the written value. The drop still chooses its bit from the state before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prebits_fld | input | 3 | Implemented preemption bits minus one |
| bp0_i | input | 3 | Binary point for group 0 |
| bp1_i | input | 3 | Binary point for group 1 |
| bp_common_i | input | 1 | Group 1 takes its binary point from group 0 |
| set_i | input | 1 | Mark a priority active |
| set_grp_i | input | 1 | Group of the priority being set |
| set_pri_i | input | 8 | Priority being set |
| drop_i | input | 1 | Remove the highest active priority |
| drop_vld_o | output | 1 | Drop result valid |
| drop_pri_o | output | 8 | Level removed by the drop, or 0xFF |
| drop_grp_o | output | 1 | Group whose bit was removed |
| run_pri_o | output | 8 | Running (highest active) priority |
| set_err_o | output | 1 | A set collided with a drop |
| wacc_we_i | input | 1 | Word write strobe |
| wacc_grp_i | input | 1 | Bank select for word access |
| wacc_idx_i | input | 2 | Word index for access |
| wacc_wdata_i | input | 32 | Word write data |
| wacc_rdata_o | output | 32 | Word read data |

## Verification
Directed sets use each binary-point source: group 0 with its +1 offset, group 1 with its own field, and group 1 under the common flag with saturation at 7. These show whether the mask, the shift and the word/bit split are each placed correctly. Drops are tried with only one bank populated, with both banks holding the same position (which must favour group 1), and with an empty state, so that the strict-less-than tie break and the idle value can be told apart. Configuration changes expose words beyond the live count and then bring them back. Simultaneous set/drop and write/set pairs separate the ordering rules. A long random run, checked against a behavioural model every clock, mixes all operations and configurations.

// File: rtl/apt_pkg.sv
package apt_pkg;

   localparam int PRI_W = 8;

   typedef logic [PRI_W-1:0] pri_t;

   // Implemented preemption bits, forced into the supported 5..7 range.
   function automatic logic [2:0] clamp_pre_bits(input logic [2:0] fld);
      logic [3:0] cnt;
      cnt = {1'b0, fld} + 4'd1;
      if (cnt < 4'd5)
         cnt = 4'd5;
      else if (cnt > 4'd7)
         cnt = 4'd7;
      return cnt[2:0];
   endfunction

endpackage

// File: rtl/apt_bpoint.sv
module apt_bpoint
   import apt_pkg::*;
#(
   parameter int IDX_W = 7
) (
   input  logic [2:0]       bp0_i,
   input  logic [2:0]       bp1_i,
   input  logic             bp_common_i,
   input  logic             grp_i,
   input  pri_t             pri_i,
   input  logic [2:0]       min_bp_i,
   output logic [IDX_W-1:0] idx_o
);

   logic [3:0] bp;
   pri_t       mask;
   pri_t       lvl;

   always_comb begin
      if (!grp_i)
         bp = {1'b0, bp0_i} + 4'd1;
      else if (bp_common_i)
         bp = (bp0_i == 3'd7) ? 4'd7 : {1'b0, bp0_i} + 4'd1;
      else
         bp = {1'b0, bp1_i};
      for (int i = 0; i < PRI_W; i++)
         mask[i] = (i >= int'(bp));
      lvl   = pri_i & mask;
      idx_o = IDX_W'(lvl >> min_bp_i);
   end

endmodule

// File: rtl/apt_lsb.sv
module apt_lsb #(
   parameter int W = 32,
   localparam int PW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec_i,
   output logic          found_o,
   output logic [PW-1:0] pos_o
);

   always_comb begin
      found_o = |vec_i;
      pos_o   = '0;
      for (int i = W - 1; i >= 0; i--)
         if (vec_i[i])
            pos_o = PW'(i);
   end

endmodule

// File: rtl/apt_bank.sv
module apt_bank #(
   parameter int NUM_WORDS = 4,
   parameter int WORD_W    = 32,
   localparam int WSEL_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
   localparam int BIT_W    = $clog2(WORD_W)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_WORDS-1:0]             word_vld_i,
   input  logic                             wr_en_i,
   input  logic [WSEL_W-1:0]                wr_sel_i,
   input  logic [WORD_W-1:0]                wr_data_i,
   input  logic                             set_en_i,
   input  logic [WSEL_W-1:0]                set_sel_i,
   input  logic [BIT_W-1:0]                 set_bit_i,
   input  logic                             clr_en_i,
   input  logic [WSEL_W-1:0]                clr_sel_i,
   input  logic [BIT_W-1:0]                 clr_bit_i,
   output logic [NUM_WORDS-1:0][WORD_W-1:0] words_o
);

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] nxt;

      always_comb begin
         nxt = words_o[w];
         if (word_vld_i[w]) begin
            if (wr_en_i && wr_sel_i == WSEL_W'(w))
               nxt = wr_data_i;
            if (set_en_i && set_sel_i == WSEL_W'(w))
               nxt[set_bit_i] = 1'b1;
            if (clr_en_i && clr_sel_i == WSEL_W'(w))
               nxt[clr_bit_i] = 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            words_o[w] <= '0;
         else
            words_o[w] <= nxt;
      end
   end

endmodule

// File: rtl/apt_tracker.sv
module apt_tracker
   import apt_pkg::*;
#(
   parameter int NUM_WORDS = 4,
   parameter int WORD_W    = 32,
   localparam int WSEL_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
   localparam int BIT_W    = $clog2(WORD_W),
   localparam int IDX_W    = PRI_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_prebits_fld,
   input  logic [2:0]        bp0_i,
   input  logic [2:0]        bp1_i,
   input  logic              bp_common_i,
   input  logic              set_i,
   input  logic              set_grp_i,
   input  logic [PRI_W-1:0]  set_pri_i,
   input  logic              drop_i,
   output logic              drop_vld_o,
   output logic [PRI_W-1:0]  drop_pri_o,
   output logic              drop_grp_o,
   output logic [PRI_W-1:0]  run_pri_o,
   output logic              set_err_o,
   input  logic              wacc_we_i,
   input  logic              wacc_grp_i,
   input  logic [WSEL_W-1:0] wacc_idx_i,
   input  logic [WORD_W-1:0] wacc_wdata_i,
   output logic [WORD_W-1:0] wacc_rdata_o
);

   // Elaboration-time parameter checks
   if (NUM_WORDS * WORD_W < (1 << IDX_W)) begin : g_bad_capacity
      $error("apt_tracker: banks too small for 7 preemption bits");
   end
   if (WORD_W != (1 << BIT_W)) begin : g_bad_word
      $error("apt_tracker: WORD_W must be a power of two");
   end
   if (NUM_WORDS != (1 << WSEL_W)) begin : g_bad_words
      $error("apt_tracker: NUM_WORDS must be a power of two above one");
   end

   // Configuration decode
   logic [2:0]           pre_bits;
   logic [2:0]           min_bp;
   logic [NUM_WORDS-1:0] word_vld;

   assign pre_bits = clamp_pre_bits(cfg_prebits_fld);
   assign min_bp   = 3'(4'd8 - {1'b0, pre_bits});

   always_comb begin
      int live;
      live = 1 << (int'(pre_bits) - 5);
      for (int w = 0; w < NUM_WORDS; w++)
         word_vld[w] = (w < live);
   end

   // Bank storage
   logic [NUM_WORDS-1:0][WORD_W-1:0] words0, words1;
   logic [IDX_W-1:0]                 set_idx;
   logic [WSEL_W-1:0]                set_sel;
   logic [BIT_W-1:0]                 set_bit;
   logic                             set_ok;
   logic [WSEL_W-1:0]                fw;
   logic                             any_act;
   logic                             pick0;
   logic [BIT_W-1:0]                 pos_m, pos0, pos1, drop_bit;
   logic                             fnd_m, fnd0, fnd1;

   apt_bpoint #(.IDX_W(IDX_W)) u_bpoint (
      .bp0_i       (bp0_i),
      .bp1_i       (bp1_i),
      .bp_common_i (bp_common_i),
      .grp_i       (set_grp_i),
      .pri_i       (set_pri_i),
      .min_bp_i    (min_bp),
      .idx_o       (set_idx)
   );

   assign set_sel = WSEL_W'(set_idx >> BIT_W);
   assign set_bit = set_idx[BIT_W-1:0];
   assign set_ok  = set_i & ~drop_i;

   for (genvar g = 0; g < 2; g++) begin : g_bank
      logic [NUM_WORDS-1:0][WORD_W-1:0] bw;
      logic                             clr_en;

      assign clr_en = drop_i & any_act & ((g == 0) ? pick0 : ~pick0);

      apt_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .word_vld_i (word_vld),
         .wr_en_i    (wacc_we_i && (wacc_grp_i == 1'(g))),
         .wr_sel_i   (wacc_idx_i),
         .wr_data_i  (wacc_wdata_i),
         .set_en_i   (set_ok && (set_grp_i == 1'(g))),
         .set_sel_i  (set_sel),
         .set_bit_i  (set_bit),
         .clr_en_i   (clr_en),
         .clr_sel_i  (fw),
         .clr_bit_i  (drop_bit),
         .words_o    (bw)
      );
   end

   assign words0 = g_bank[0].bw;
   assign words1 = g_bank[1].bw;

   // Lowest live word holding any active bit
   always_comb begin
      any_act = 1'b0;
      fw      = '0;
      for (int w = NUM_WORDS - 1; w >= 0; w--) begin
         if (word_vld[w] && ((words0[w] | words1[w]) != '0)) begin
            any_act = 1'b1;
            fw      = WSEL_W'(w);
         end
      end
   end

   apt_lsb #(.W(WORD_W)) u_lsb_m (
      .vec_i (words0[fw] | words1[fw]), .found_o (fnd_m), .pos_o (pos_m));
   apt_lsb #(.W(WORD_W)) u_lsb_0 (
      .vec_i (words0[fw]), .found_o (fnd0), .pos_o (pos0));
   apt_lsb #(.W(WORD_W)) u_lsb_1 (
      .vec_i (words1[fw]), .found_o (fnd1), .pos_o (pos1));

   // Running priority and drop choice
   logic [BIT_W:0] c0, c1;
   pri_t           run_lvl, drop_lvl;

   always_comb begin
      c0       = fnd0 ? {1'b0, pos0} : (BIT_W+1)'(WORD_W);
      c1       = fnd1 ? {1'b0, pos1} : (BIT_W+1)'(WORD_W);
      pick0    = (c0 < c1);
      drop_bit = pick0 ? pos0 : pos1;
      run_lvl  = PRI_W'({fw, pos_m});
      drop_lvl = PRI_W'({fw, drop_bit});
      run_pri_o = (any_act && fnd_m) ? pri_t'(run_lvl << min_bp) : '1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drop_vld_o <= 1'b0;
         drop_pri_o <= '0;
         drop_grp_o <= 1'b0;
         set_err_o  <= 1'b0;
      end else begin
         drop_vld_o <= drop_i;
         set_err_o  <= set_i & drop_i;
         if (drop_i) begin
            drop_pri_o <= any_act ? pri_t'(drop_lvl << min_bp) : '1;
            drop_grp_o <= any_act & ~pick0;
         end
      end
   end

   // Word read
   always_comb begin
      if (!word_vld[wacc_idx_i])
         wacc_rdata_o = '0;
      else if (wacc_grp_i)
         wacc_rdata_o = words1[wacc_idx_i];
      else
         wacc_rdata_o = words0[wacc_idx_i];
   end

endmodule

// File: rtl/apt_tracker_chk.sv
module apt_tracker_chk #(
   parameter int WSEL_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cfg_prebits_fld,
   input logic              set_i,
   input logic              drop_i,
   input logic              drop_vld_o,
   input logic [7:0]        drop_pri_o,
   input logic [7:0]        run_pri_o,
   input logic              set_err_o,
   input logic              wacc_we_i,
   input logic [WSEL_W-1:0] wacc_idx_i,
   input logic [31:0]       wacc_rdata_o
);

   AST_DROP_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
      drop_i |=> drop_vld_o); // R7

   AST_REPORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      drop_vld_o |-> $past(drop_i)); // R7

   AST_DROP_EQ_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      drop_i |=> (drop_pri_o == $past(run_pri_o))); // R6

   AST_EMPTY_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_i && run_pri_o == 8'hFF) |=> (drop_pri_o == 8'hFF)); // R8

   AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && drop_i) |=> set_err_o); // R10

   AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      set_err_o |-> $past(set_i && drop_i)); // R10

   AST_SET_NO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !drop_i && !wacc_we_i) |=>
         ((run_pri_o <= $past(run_pri_o)) || !$stable(cfg_prebits_fld))); // R5

   AST_DEAD_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_prebits_fld <= 3'd4 && wacc_idx_i != '0) |-> (wacc_rdata_o == 32'h0)); // R9

endmodule

bind apt_tracker apt_tracker_chk #(.WSEL_W(WSEL_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_prebits_fld (cfg_prebits_fld),
   .set_i           (set_i),
   .drop_i          (drop_i),
   .drop_vld_o      (drop_vld_o),
   .drop_pri_o      (drop_pri_o),
   .run_pri_o       (run_pri_o),
   .set_err_o       (set_err_o),
   .wacc_we_i       (wacc_we_i),
   .wacc_idx_i      (wacc_idx_i),
   .wacc_rdata_o    (wacc_rdata_o)
);

// File: tb/sim_apt_tracker.sv
`timescale 1ns/1ps
module sim_apt_tracker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_prebits_fld = 3'd6;
   logic [2:0]  bp0_i = 3'd0, bp1_i = 3'd0;
   logic        bp_common_i = 1'b0;
   logic        set_i = 1'b0, set_grp_i = 1'b0;
   logic [7:0]  set_pri_i = 8'h0;
   logic        drop_i = 1'b0;
   logic        drop_vld_o, drop_grp_o, set_err_o;
   logic [7:0]  drop_pri_o, run_pri_o;
   logic        wacc_we_i = 1'b0, wacc_grp_i = 1'b0;
   logic [1:0]  wacc_idx_i = 2'd0;
   logic [31:0] wacc_wdata_i = 32'h0;
   logic [31:0] wacc_rdata_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_cnt = 0;

   always #4 clk = ~clk;

   apt_tracker u0 (.*);

   // ---------------- behavioural reference ----------------
   logic [31:0] mb [2][4];
   logic        e_dv, e_dg, e_err;
   logic [7:0]  e_dp;

   function automatic int bits_of(input logic [2:0] f);
      int b = int'(f) + 1;
      if (b < 5) b = 5;
      if (b > 7) b = 7;
      return b;
   endfunction

   function automatic int ffs(input logic [31:0] v);
      for (int i = 0; i < 32; i++)
         if (v[i]) return i;
      return 32;
   endfunction

   function automatic int first_word();
      int nw = 1 << (bits_of(cfg_prebits_fld) - 5);
      for (int w = 0; w < nw; w++)
         if ((mb[0][w] | mb[1][w]) != 0) return w;
      return -1;
   endfunction

   function automatic logic [7:0] exp_run();
      int fw = first_word();
      int mbp = 8 - bits_of(cfg_prebits_fld);
      if (fw < 0) return 8'hFF;
      return 8'(((fw * 32) + ffs(mb[0][fw] | mb[1][fw])) << mbp);
   endfunction

   function automatic logic [31:0] exp_rd();
      int nw = 1 << (bits_of(cfg_prebits_fld) - 5);
      if (int'(wacc_idx_i) >= nw) return 32'h0;
      return mb[wacc_grp_i][wacc_idx_i];
   endfunction

   task automatic model_step();
      int nw  = 1 << (bits_of(cfg_prebits_fld) - 5);
      int mbp = 8 - bits_of(cfg_prebits_fld);
      int fw  = first_word();
      int cg  = -1;
      int cb  = 0;
      int bp, ix;
      logic [7:0] lvl;
      e_dv  = drop_i;
      e_err = set_i && drop_i;
      if (drop_i) begin
         if (fw < 0) begin
            e_dp = 8'hFF; e_dg = 1'b0;
         end else begin
            int c0 = ffs(mb[0][fw]);
            int c1 = ffs(mb[1][fw]);
            if (c0 < c1) begin cg = 0; cb = c0; end
            else begin cg = 1; cb = c1; end
            e_dp = 8'(((fw * 32) + cb) << mbp);
            e_dg = (cg == 1);
         end
      end
      if (wacc_we_i && int'(wacc_idx_i) < nw)
         mb[wacc_grp_i][wacc_idx_i] = wacc_wdata_i;
      if (set_i && !drop_i) begin
         if (!set_grp_i) bp = int'(bp0_i) + 1;
         else if (bp_common_i) bp = (int'(bp0_i) + 1 > 7) ? 7 : int'(bp0_i) + 1;
         else bp = int'(bp1_i);
         lvl = set_pri_i & 8'((16'hFF << bp) & 16'hFF);
         ix  = int'(lvl) >> mbp;
         mb[set_grp_i][ix / 32][ix % 32] = 1'b1;
      end
      if (cg >= 0)
         mb[cg][fw][cb] = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (!rst_n) begin
         for (int g = 0; g < 2; g++)
            for (int w = 0; w < 4; w++)
               mb[g][w] = 32'h0;
         e_dv = 1'b0; e_dp = 8'h0; e_dg = 1'b0; e_err = 1'b0;
      end else begin
         model_step();
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc_cnt);
      end
   endtask

   task automatic compare_all();
      chk(32'(run_pri_o), 32'(exp_run()), "R6 running priority");
      chk(32'(drop_vld_o), 32'(e_dv), "R7 drop valid");
      if (e_dv) begin
         chk(32'(drop_pri_o), 32'(e_dp), "R7 drop level");
         chk(32'(drop_grp_o), 32'(e_dg), "R7 drop group");
      end
      chk(32'(set_err_o), 32'(e_err), "R10 collision flag");
      chk(wacc_rdata_o, exp_rd(), "R9 word read");
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      if (rst_n) compare_all();
      set_i = 1'b0; drop_i = 1'b0; wacc_we_i = 1'b0;
   endtask

   task automatic do_set(input logic g, input logic [7:0] p);
      set_i = 1'b1; set_grp_i = g; set_pri_i = p;
      cyc();
   endtask

   task automatic do_wr(input logic g, input logic [1:0] i, input logic [31:0] d);
      wacc_we_i = 1'b1; wacc_grp_i = g; wacc_idx_i = i; wacc_wdata_i = d;
      cyc();
   endtask

   task automatic rd(input logic g, input logic [1:0] i);
      wacc_grp_i = g; wacc_idx_i = i;
      #1;
   endtask

   task automatic clear_all();
      for (int g = 0; g < 2; g++)
         for (int w = 0; w < 4; w++)
            do_wr(1'(g), 2'(w), 32'h0);
   endtask

   // watchdog
   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(32'(run_pri_o), 32'hFF, "R1 idle running priority");
      chk(32'(drop_vld_o), 32'h0, "R1 drop valid clear");
      chk(32'(set_err_o), 32'h0, "R1 flag clear");
      rd(1'b1, 2'd3);
      chk(wacc_rdata_o, 32'h0, "R1 word zero");

      // 5 preemption bits: group 0, bp0=2 -> mask F8, 0x48 -> index 9
      cfg_prebits_fld = 3'd4; bp0_i = 3'd2;
      do_set(1'b0, 8'h48);
      rd(1'b0, 2'd0);
      chk(wacc_rdata_o, 32'h0000_0200, "R5 bit 9 of word 0");
      chk(32'(run_pri_o), 32'h48, "R6 level 9 rescaled");
      drop_i = 1'b1; cyc();
      chk(32'(drop_pri_o), 32'h48, "R7 dropped level");
      chk(32'(drop_grp_o), 32'h0, "R7 dropped group 0");
      chk(32'(run_pri_o), 32'hFF, "R7 nothing left");
      drop_i = 1'b1; cyc();
      chk(32'(drop_pri_o), 32'hFF, "R8 empty drop");
      chk(32'(drop_grp_o), 32'h0, "R8 empty drop group");

      // 7 preemption bits: group 0, bp0=4 -> mask E0, 0x5C -> 0x40 -> index 32
      cfg_prebits_fld = 3'd6; bp0_i = 3'd4;
      do_set(1'b0, 8'h5C);
      rd(1'b0, 2'd1);
      chk(wacc_rdata_o, 32'h1, "R3 group 0 masked into word 1");
      chk(32'(run_pri_o), 32'h40, "R3 running after set");

      // group 1 common, bp0=7 saturates to 7: 0xC3 -> 0x80 -> index 64
      bp0_i = 3'd7; bp_common_i = 1'b1;
      do_set(1'b1, 8'hC3);
      rd(1'b1, 2'd2);
      chk(wacc_rdata_o, 32'h1, "R4 common saturated");
      // group 1 own, bp1=1: 0x23 -> 0x22 -> index 17
      bp_common_i = 1'b0; bp1_i = 3'd1;
      do_set(1'b1, 8'h23);
      rd(1'b1, 2'd0);
      chk(wacc_rdata_o, 32'h0002_0000, "R4 own binary point");
      chk(32'(run_pri_o), 32'h22, "R6 lowest word wins");

      // tie: both banks hold bit 17 of word 0
      do_wr(1'b0, 2'd0, 32'h0002_0000);
      drop_i = 1'b1; cyc();
      chk(32'(drop_grp_o), 32'h1, "R7 tie clears group 1");
      chk(32'(drop_pri_o), 32'h22, "R7 tie level");
      rd(1'b0, 2'd0);
      chk(wacc_rdata_o, 32'h0002_0000, "R7 group 0 kept");
      drop_i = 1'b1; cyc();
      chk(32'(drop_grp_o), 32'h0, "R7 then group 0");

      // 6 bits: two live words
      cfg_prebits_fld = 3'd5;
      do_wr(1'b0, 2'd3, 32'hDEAD_BEEF);
      cfg_prebits_fld = 3'd6;
      rd(1'b0, 2'd3);
      chk(wacc_rdata_o, 32'h0, "R2 write beyond live words ignored");
      cfg_prebits_fld = 3'd1;
      rd(1'b0, 2'd1);
      chk(wacc_rdata_o, 32'h0, "R2 clamped to one word");
      chk(32'(run_pri_o), 32'hFF, "R2 hidden words not active");
      cfg_prebits_fld = 3'd6;
      rd(1'b0, 2'd1);
      chk(wacc_rdata_o, 32'h1, "R2 word kept while hidden");

      // collision on empty state
      clear_all();
      bp0_i = 3'd0;
      set_i = 1'b1; set_grp_i = 1'b0; set_pri_i = 8'h02; drop_i = 1'b1;
      cyc();
      chk(32'(set_err_o), 32'h1, "R10 collision flagged");
      chk(32'(run_pri_o), 32'hFF, "R10 set discarded");

      // write and set in the same cycle: bp1=0, 0x08 -> index 4
      bp1_i = 3'd0;
      wacc_we_i = 1'b1; wacc_grp_i = 1'b1; wacc_idx_i = 2'd0; wacc_wdata_i = 32'h1;
      set_i = 1'b1; set_grp_i = 1'b1; set_pri_i = 8'h08;
      cyc();
      rd(1'b1, 2'd0);
      chk(wacc_rdata_o, 32'h11, "R11 set on top of write");

      // random mix against the model
      for (int k = 0; k < 6000; k++) begin
         if ($urandom_range(63) == 0) cfg_prebits_fld = 3'($urandom_range(7));
         bp0_i        = 3'($urandom_range(7));
         bp1_i        = 3'($urandom_range(7));
         bp_common_i  = 1'($urandom_range(1));
         set_i        = ($urandom_range(2) == 0);
         set_grp_i    = 1'($urandom_range(1));
         set_pri_i    = 8'($urandom_range(255));
         drop_i       = ($urandom_range(3) == 0);
         wacc_we_i    = ($urandom_range(11) == 0);
         wacc_grp_i   = 1'($urandom_range(1));
         wacc_idx_i   = 2'($urandom_range(3));
         wacc_wdata_i = (1 << $urandom_range(31)) | (1 << $urandom_range(31));
         cyc();
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule